// File: doc/BRIEF.md
# Oscillator Warm-Up Interval Counter

This block times the settling interval of a low-frequency oscillator that has just been enabled, before the system is moved onto that clock. Two chained byte-wide counter stages, clocked by the oscillator under test, form one wide up-counter. Only the upper stage is compared against the upper byte of a programmed compare register. The warm-up delay is therefore set in whole steps of 256 source clocks. On a match the counter restarts from zero, and a match event crosses into the system clock domain, where it sets a sticky interrupt flag.

Software writes the compare register and then sets the run bit. It waits for the interrupt, then clears the run bit before it switches the system clock over. A register interface holds the run bit, a warm-up mode select, per-stage timer output enables and the interrupt flag. While warm-up mode is selected the timer outputs are held low, whatever the enables hold.

Top module: `warmup_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0x0002 (run bit 0 clear, mode bit 1 set, output enable bits 3:2 clear). The compare register (address 1) and the status register (address 2) read 0. `irq_o` and `timer_o` are 0.
- R2: With compare upper byte N (1 to 255), `irq_o` rises between N*256+1 and N*256+8 source clock edges after the write that sets the run bit.
- R3: On a match the counter clears to zero and keeps running. The next interrupt follows N*256 source clocks (within 2) after the previous one.
- R4: Bits 7:0 of the compare register have no effect on the interval. 0x01FF times out like 0x0100.
- R5: A compare upper byte of 0x00 gives an interval of 65536 source clocks, not an immediate match.
- R6: Clearing the run bit stops the counter and returns it to zero. A later start times a full interval and does not resume the old count.
- R7: A compare write while running does not change the running interval. The new value applies from the next start. The register reads back the written value at once.
- R8: The status flag (bit 0 of address 2) stays set until bit 0 is written with 1. Writing 0 leaves it set.
- R9: With the mode bit set, `timer_o` is 0 whatever the enables hold. With it clear, `timer_o` follows control bits 3:2 one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| lf_clk_i | input | 1 | Low-frequency source clock being warmed up |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 compare, 2 status |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` |
| irq_o | output | 1 | Sticky match interrupt |
| timer_o | output | 2 | Per-stage timer outputs, low in warm-up mode |

## Verification
The counter assertions take for granted that the captured compare byte does not change while the source-domain run signal is high. That only holds if software does not clear the run bit and set it again within about two source clocks. The stimulus therefore always waits several source clocks after a stop before it restarts. The assertions also assume the source clock is slower than the system clock, so that match toggles, which are at least 256 source clocks apart, are never lost in the synchronizer. The bench drives a source clock at half the system rate and writes registers only on system falling edges.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CMP  = 2'd1,
    REG_STAT = 2'd2
  } wu_reg_e;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_WU  = 1;
  localparam int unsigned CTRL_TFF = 2;
endpackage

// File: rtl/wu_sync.sv
module wu_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[DEPTH-2:0], d_i};
  end

  assign q_o = ff_q[DEPTH-1];
endmodule

// File: rtl/wu_stage.sv
module wu_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         full_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (clr_i) q_q <= '0;
    else if (inc_i) q_q <= q_q + 1'b1;
  end

  assign q_o    = q_q;
  assign full_o = &q_q;
endmodule

// File: rtl/wu_counter.sv
module wu_counter #(
  parameter int unsigned STAGE_W = 8,
  parameter int unsigned STAGES  = 2
) (
  input  logic               lf_clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [STAGE_W-1:0] cmp_hi_i,
  output logic               match_tgl_o
);
  localparam int unsigned TW  = STAGE_W + 1;
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGE_W-1:0] q [STAGES];
  logic [STAGES-1:0]  cy;
  logic [STAGES-1:0]  full;
  logic [TW-1:0]      tgt;
  logic [TW-1:0]      up_nxt;
  logic               match_p;
  logic               clr;
  logic               tgl_q;

  assign cy[0] = run_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    wu_stage #(.W(STAGE_W)) u_stg (
      .clk_i  (lf_clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .inc_i  (cy[k]),
      .q_o    (q[k]),
      .full_o (full[k])
    );
    if (k < TOP) begin : g_cy
      assign cy[k+1] = cy[k] & full[k];
    end
  end

  // zero compare byte means a full wrap of the upper stage
  assign tgt     = (cmp_hi_i == '0) ? {1'b1, {STAGE_W{1'b0}}} : {1'b0, cmp_hi_i};
  assign up_nxt  = {1'b0, q[TOP]} + 1'b1;
  assign match_p = cy[TOP] & (up_nxt == tgt);
  assign clr     = ~run_i | match_p;

  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni)      tgl_q <= 1'b0;
    else if (match_p) tgl_q <= ~tgl_q;
  end

  assign match_tgl_o = tgl_q;

  AST_IDLE_CLEAR: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    !run_i |=> (q[0] == '0 && q[TOP] == '0)); // R6
  AST_CLEAR_ON_MATCH: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    match_p |=> (q[0] == '0 && q[TOP] == '0)); // R3
  AST_UPPER_BELOW: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    run_i |-> ({1'b0, q[TOP]} < tgt)); // R2
  AST_NO_WRAP: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (cy[TOP] && full[TOP]) |-> match_p); // R5
endmodule

// File: rtl/warmup_timer.sv
module warmup_timer #(
  parameter int unsigned STAGE_W = 8,
  parameter int unsigned STAGES  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         lf_clk_i,
  input  logic                         we_i,
  input  logic [1:0]                   addr_i,
  input  logic [STAGE_W*STAGES-1:0]    wdata_i,
  output logic [STAGE_W*STAGES-1:0]    rdata_o,
  output logic                         irq_o,
  output logic [STAGES-1:0]            timer_o
);
  import wu_pkg::*;

  localparam int unsigned DW     = STAGE_W * STAGES;
  localparam int unsigned CTRL_W = CTRL_TFF + STAGES;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << CTRL_WU;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [DW-1:0]      cmp_q;
  logic [STAGE_W-1:0] shadow_q;
  logic               flag_q;
  logic [STAGES-1:0]  timer_q;
  logic               wr_ctrl, wr_cmp, clr_wr, start_rise;
  logic               run_lf, tgl_lf, tgl_s, tgl_d, evt;

  assign wr_ctrl    = we_i && (addr_i == REG_CTRL);
  assign wr_cmp     = we_i && (addr_i == REG_CMP);
  assign clr_wr     = we_i && (addr_i == REG_STAT) && wdata_i[0];
  assign start_rise = wr_ctrl && wdata_i[CTRL_RUN] && !ctrl_q[CTRL_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      cmp_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (wr_ctrl)    ctrl_q   <= wdata_i[CTRL_W-1:0];
      if (wr_cmp)     cmp_q    <= wdata_i;
      if (start_rise) shadow_q <= cmp_q[DW-1 -: STAGE_W];
    end
  end

  wu_sync #(.DEPTH(2)) u_run_sync (
    .clk_i  (lf_clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctrl_q[CTRL_RUN]),
    .q_o    (run_lf)
  );

  wu_counter #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_cnt (
    .lf_clk_i    (lf_clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_lf),
    .cmp_hi_i    (shadow_q),
    .match_tgl_o (tgl_lf)
  );

  wu_sync #(.DEPTH(2)) u_evt_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tgl_lf),
    .q_o    (tgl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_d   <= 1'b0;
      flag_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      tgl_d   <= tgl_s;
      timer_q <= ctrl_q[CTRL_WU] ? '0 : ctrl_q[CTRL_TFF +: STAGES];
      if (evt)         flag_q <= 1'b1;
      else if (clr_wr) flag_q <= 1'b0;
    end
  end

  assign evt = tgl_s ^ tgl_d;

  always_comb begin
    case (addr_i)
      REG_CTRL: rdata_o = DW'(ctrl_q);
      REG_CMP:  rdata_o = cmp_q;
      REG_STAT: rdata_o = DW'(flag_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o   = flag_q;
  assign timer_o = timer_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_wr) |=> flag_q); // R8
  AST_FLAG_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> flag_q); // R2
  AST_TIMER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_q[CTRL_WU]) |-> (timer_o == '0)); // R9
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTRL_RUN] && $past(ctrl_q[CTRL_RUN])) |-> $stable(shadow_q)); // R7
endmodule

// File: tb/sim_warmup_timer.sv
module sim_warmup_timer;
  logic        clk = 1'b0, lf_clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [1:0]  timer;
  int unsigned lf_cnt = 0;
  int total = 0, bad = 0;

  warmup_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .lf_clk_i(lf_clk), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .timer_o(timer)
  );

  always #5 clk = ~clk;
  initial begin #3; forever #10 lf_clk = ~lf_clk; end
  always @(posedge lf_clk) lf_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic start_run(output int unsigned t0);
    wr(2'd0, 16'h0003); t0 = lf_cnt;
  endtask

  task automatic stop_clear();
    wr(2'd0, 16'h0002);
    repeat (8) @(posedge lf_clk);
    wr(2'd2, 16'h0001);
  endtask

  task automatic wait_irq(input int unsigned t0, input int unsigned lim, output int unsigned d);
    while (!irq && (lf_cnt - t0) <= lim) @(negedge clk);
    d = lf_cnt - t0;
  endtask

  task automatic chk_window(input string req, input int unsigned d, input int unsigned n);
    int unsigned base = n * 256;
    chk(d >= base + 1 && d <= base + 8, req, int'(d), int'(base + 4));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk(v == 16'h0002, "R1 ctrl", v, 2);
    rd(2'd1, v); chk(v == 16'h0000, "R1 cmp", v, 0);
    rd(2'd2, v); chk(v == 16'h0000, "R1 stat", v, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(timer == 2'b00, "R1 timer", timer, 0);
  endtask

  task automatic t_period(input logic [15:0] cmp, input int unsigned n, input string req);
    int unsigned t0, d;
    wr(2'd1, cmp);
    start_run(t0);
    wait_irq(t0, n * 256 + 64, d);
    chk_window(req, d, n);
    stop_clear();
  endtask

  task automatic t_repeat();
    int unsigned t0, t1, d1, d2, diff;
    wr(2'd1, 16'h0200);
    start_run(t0);
    wait_irq(t0, 600, d1);
    chk_window("R3 first", d1, 2);
    t1 = lf_cnt;
    wr(2'd2, 16'h0001);
    wait_irq(t1, 600, d2);
    diff = (d2 > 512) ? d2 - 512 : 512 - d2;
    chk(diff <= 2, "R3 repeat interval", int'(d2), 512);
    stop_clear();
  endtask

  task automatic t_stop();
    int unsigned t0, d;
    wr(2'd1, 16'h0100);
    start_run(t0);
    repeat (200) @(posedge lf_clk);
    wr(2'd0, 16'h0002);
    repeat (400) @(posedge lf_clk);
    @(negedge clk);
    chk(irq == 1'b0, "R6 no irq while stopped", irq, 0);
    start_run(t0);
    wait_irq(t0, 400, d);
    chk_window("R6 restart from zero", d, 1);
    stop_clear();
  endtask

  task automatic t_midwrite();
    int unsigned t0, d;
    logic [15:0] v;
    wr(2'd1, 16'h0100);
    start_run(t0);
    repeat (50) @(posedge lf_clk);
    wr(2'd1, 16'h0300);
    rd(2'd1, v); chk(v == 16'h0300, "R7 readback", v, 16'h0300);
    wait_irq(t0, 900, d);
    chk_window("R7 running interval kept", d, 1);
    stop_clear();
    start_run(t0);
    wait_irq(t0, 900, d);
    chk_window("R7 new value at restart", d, 3);
    stop_clear();
  endtask

  task automatic t_flag();
    int unsigned t0, d;
    logic [15:0] v;
    wr(2'd1, 16'h0100);
    start_run(t0);
    wait_irq(t0, 400, d);
    wr(2'd0, 16'h0002);
    repeat (8) @(posedge lf_clk);
    rd(2'd2, v); chk(v == 16'h0001, "R8 stat set", v, 1);
    wr(2'd2, 16'h0000);
    repeat (20) @(posedge lf_clk);
    @(negedge clk);
    chk(irq == 1'b1, "R8 write 0 keeps flag", irq, 1);
    wr(2'd2, 16'h0001);
    chk(irq == 1'b0, "R8 write 1 clears", irq, 0);
  endtask

  task automatic t_timer();
    wr(2'd0, 16'h000E);
    @(negedge clk);
    chk(timer == 2'b00, "R9 forced low in warm-up", timer, 0);
    wr(2'd0, 16'h000C);
    @(negedge clk);
    chk(timer == 2'b11, "R9 follows enables", timer, 3);
    wr(2'd0, 16'h0004);
    @(negedge clk);
    chk(timer == 2'b01, "R9 single enable", timer, 1);
    wr(2'd0, 16'h0002);
    @(negedge clk);
    chk(timer == 2'b00, "R9 back to warm-up", timer, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_period(16'h0100, 1, "R2 N=1");
    t_period(16'h0300, 3, "R2 N=3");
    t_repeat();
    t_period(16'h01FF, 1, "R4 low byte ignored");
    t_stop();
    t_midwrite();
    t_flag();
    t_timer();
    t_period(16'h0000, 256, "R5 zero means 65536");
    summary();
  end
endmodule